// File: doc/BRIEF.md
# Debug Breakpoint Trigger Unit

This block watches the processor's program counter and its operand bus traffic, and raises a breakpoint action when programmed conditions are met. Three conditions are tested on each cycle:

- **Program counter:** checked against a reference value, with some bits masked off.
- **Operand address:** checked against an inclusive window with a low bound and a high bound.
- **Data value:** checked against a reference value, with some bits masked off.

The address and data conditions also require a valid bus cycle and matching bus attributes.

A configuration register picks which conditions make up each trigger level. It also chooses between a single-level trigger and a two-level sequential trigger, and picks the resulting action: a halt request or a debug interrupt request. Both actions are one-cycle pulses.

Software programs the unit through a simple register write port. This port stands in for the debug serial channel or a privileged write instruction. A status output shows the level currently armed and a sticky flag recording that the trigger has fired.

Top module: `dbg_trigger`

## Requirements
- R1: After reset, haltReq and irqReq are low, trigLevel is 0 (disabled) and trigHit is 0. No action occurs until the config register enables the unit.
- R2: The PC condition is true when every bit of pcVal not set in the PC mask register (address 2) equals the PC reference register (address 1). A mask bit of 1 means that bit is ignored.
- R3: The address condition is true when busValid is high and busAddr lies between the low bound (address 3) and the high bound (address 4), both bounds included.
- R4: The data condition is true when busValid is high and every bit of busData not set in the data mask register (address 6) equals the data reference register (address 5).
- R5: The address and data conditions also require busAttr to equal attribute register bits [7:0] on every bit where attribute register bits [15:8] hold 0.
- R6: Config register (address 0) bits [2:0] enable conditions for level 1, and bits [5:3] enable conditions for level 2. Within each group, bit 0 is PC, bit 1 is address and bit 2 is data. A level is hit when all of its enabled conditions are true. A level with no enabled conditions is never hit.
- R7: With config bit 8 (enable) set and bit 6 clear (single level), a level-1 hit in a cycle produces an action pulse one clock later, and a pulse follows every such cycle.
- R8: With bit 6 set (two level), a level-1 hit moves trigLevel from 1 to 2 without any action. In level 2, a level-2 hit produces the action and returns trigLevel to 1. Level-2 hits while in level 1 are ignored.
- R9: Config bit 7 selects the action: 0 gives a one-cycle haltReq pulse, and 1 gives a one-cycle irqReq pulse. The two are never high together.
- R10: trigHit is set with each action pulse and stays set until the config register is written. A config write clears trigHit, sets trigLevel to 1 if the new bit 8 is set and to 0 otherwise, and suppresses any action in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register select: 0 config, 1 PC ref, 2 PC mask, 3 addr low, 4 addr high, 5 data ref, 6 data mask, 7 attribute |
| cfgData | input | 32 | Register write data |
| pcVal | input | 32 | Current program counter |
| busAddr | input | 32 | Operand address |
| busData | input | 32 | Operand data |
| busAttr | input | 8 | Bus attributes of the access |
| busValid | input | 1 | Bus cycle valid |
| haltReq | output | 1 | One-cycle halt request |
| irqReq | output | 1 | One-cycle debug interrupt request |
| trigLevel | output | 2 | Armed level: 0 disabled, 1 level 1, 2 level 2 |
| trigHit | output | 1 | Sticky fired flag |

## Verification
A config write can fall in the same cycle as a qualifying trigger hit. The bench provokes this by writing the config register while pcVal matches an enabled PC condition. It also does so in the random phase, where config writes land among biased near-match bus traffic. The write must win: no pulse follows, trigHit reads 0, and trigLevel shows the value set by the newly written enable bit. A per-cycle reference model in the bench judges each of these outcomes.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  typedef enum logic [2:0] {
    REG_CFG   = 3'd0,
    REG_PCREF = 3'd1,
    REG_PCMSK = 3'd2,
    REG_ALO   = 3'd3,
    REG_AHI   = 3'd4,
    REG_DREF  = 3'd5,
    REG_DMSK  = 3'd6,
    REG_ATTR  = 3'd7
  } regSel_e;

  typedef enum logic [1:0] {
    LVL_OFF = 2'd0,
    LVL_ONE = 2'd1,
    LVL_TWO = 2'd2
  } lvl_e;

  localparam int NCOND   = 3;
  localparam int NLEVEL  = 2;
  localparam int CFG_TWO = 6;
  localparam int CFG_ACT = 7;
  localparam int CFG_ENA = 8;
  localparam int CFG_W   = 9;

  typedef struct packed {
    logic fire;
    logic armTwo;
    logic disarm;
  } ctrlStrobe_t;
endpackage

// File: rtl/dbg_trig_datapath.sv
module dbg_trig_datapath
  import dbg_trig_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int ATTRW = 8,
  parameter int WW = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [2:0]       cfgAddr,
  input  logic [WW-1:0]    cfgData,
  input  logic [AW-1:0]    pcVal,
  input  logic [AW-1:0]    busAddr,
  input  logic [DW-1:0]    busData,
  input  logic [ATTRW-1:0] busAttr,
  input  logic             busValid,
  input  ctrlStrobe_t      strb,
  output logic [NLEVEL-1:0] lvlHit,
  output logic             twoLvl,
  output logic             actIrq,
  output logic             trigOn,
  output logic             cfgWrite,
  output lvl_e             lvl,
  output logic             hitFlag
);
  logic [CFG_W-1:0] cfgQ;
  logic [AW-1:0]    pcRef, pcMask, addrLo, addrHi;
  logic [DW-1:0]    dataRef, dataMask;
  logic [ATTRW-1:0] attrRef, attrMask;
  logic [NCOND-1:0] condVec;
  logic             attrOk, pcMatch, addrMatch, dataMatch;

  assign cfgWrite = cfgWe && (regSel_e'(cfgAddr) == REG_CFG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ     <= '0;
      pcRef    <= '0;
      pcMask   <= '0;
      addrLo   <= '0;
      addrHi   <= '0;
      dataRef  <= '0;
      dataMask <= '0;
      attrRef  <= '0;
      attrMask <= '0;
    end else if (cfgWe) begin
      unique case (regSel_e'(cfgAddr))
        REG_CFG:   cfgQ     <= cfgData[CFG_W-1:0];
        REG_PCREF: pcRef    <= cfgData[AW-1:0];
        REG_PCMSK: pcMask   <= cfgData[AW-1:0];
        REG_ALO:   addrLo   <= cfgData[AW-1:0];
        REG_AHI:   addrHi   <= cfgData[AW-1:0];
        REG_DREF:  dataRef  <= cfgData[DW-1:0];
        REG_DMSK:  dataMask <= cfgData[DW-1:0];
        REG_ATTR: begin
          attrRef  <= cfgData[ATTRW-1:0];
          attrMask <= cfgData[2*ATTRW-1:ATTRW];
        end
        default: ;
      endcase
    end
  end

  assign attrOk    = ((busAttr ^ attrRef) & ~attrMask) == '0;
  assign pcMatch   = ((pcVal ^ pcRef) & ~pcMask) == '0;
  assign addrMatch = busValid && attrOk && (busAddr >= addrLo) && (busAddr <= addrHi);
  assign dataMatch = busValid && attrOk && (((busData ^ dataRef) & ~dataMask) == '0);
  assign condVec   = {dataMatch, addrMatch, pcMatch};

  for (genvar g = 0; g < NLEVEL; g++) begin : g_level
    logic [NCOND-1:0] enSel;
    assign enSel     = cfgQ[g*NCOND +: NCOND];
    assign lvlHit[g] = (|enSel) && ((condVec & enSel) == enSel);
  end

  assign twoLvl = cfgQ[CFG_TWO];
  assign actIrq = cfgQ[CFG_ACT];
  assign trigOn = cfgQ[CFG_ENA];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvl     <= LVL_OFF;
      hitFlag <= 1'b0;
    end else if (cfgWrite) begin
      lvl     <= cfgData[CFG_ENA] ? LVL_ONE : LVL_OFF;
      hitFlag <= 1'b0;
    end else begin
      if (strb.fire) hitFlag <= 1'b1;
      if (strb.armTwo)      lvl <= LVL_TWO;
      else if (strb.disarm) lvl <= LVL_ONE;
    end
  end
endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
#(
  parameter int NLV = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NLV-1:0] lvlHit,
  input  logic           twoLvl,
  input  logic           actIrq,
  input  logic           trigOn,
  input  logic           cfgWrite,
  input  lvl_e           lvl,
  output ctrlStrobe_t    strb,
  output logic           haltReq,
  output logic           irqReq
);
  always_comb begin
    strb = '0;
    if (trigOn && !cfgWrite) begin
      if (!twoLvl) begin
        strb.fire = lvlHit[0];
      end else if (lvl == LVL_TWO) begin
        strb.fire   = lvlHit[1];
        strb.disarm = lvlHit[1];
      end else begin
        strb.armTwo = lvlHit[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltReq <= 1'b0;
      irqReq  <= 1'b0;
    end else begin
      haltReq <= strb.fire && !actIrq;
      irqReq  <= strb.fire && actIrq;
    end
  end
endmodule

// File: rtl/dbg_trigger.sv
module dbg_trigger
  import dbg_trig_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int ATTRW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [2:0]       cfgAddr,
  input  logic [((AW > DW) ? AW : DW)-1:0] cfgData,
  input  logic [AW-1:0]    pcVal,
  input  logic [AW-1:0]    busAddr,
  input  logic [DW-1:0]    busData,
  input  logic [ATTRW-1:0] busAttr,
  input  logic             busValid,
  output logic             haltReq,
  output logic             irqReq,
  output logic [1:0]       trigLevel,
  output logic             trigHit
);
  localparam int WW = (AW > DW) ? AW : DW;

  ctrlStrobe_t       strb;
  logic [NLEVEL-1:0] lvlHit;
  logic              twoLvl, actIrq, trigOn, cfgWrite;
  lvl_e              lvl;

  dbg_trig_datapath #(.AW(AW), .DW(DW), .ATTRW(ATTRW), .WW(WW)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .pcVal(pcVal), .busAddr(busAddr), .busData(busData), .busAttr(busAttr),
    .busValid(busValid), .strb(strb), .lvlHit(lvlHit), .twoLvl(twoLvl),
    .actIrq(actIrq), .trigOn(trigOn), .cfgWrite(cfgWrite), .lvl(lvl),
    .hitFlag(trigHit)
  );

  dbg_trig_ctrl #(.NLV(NLEVEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .lvlHit(lvlHit), .twoLvl(twoLvl), .actIrq(actIrq),
    .trigOn(trigOn), .cfgWrite(cfgWrite), .lvl(lvl), .strb(strb),
    .haltReq(haltReq), .irqReq(irqReq)
  );

  assign trigLevel = lvl;
endmodule

// File: rtl/dbg_trigger_chk.sv
module dbg_trigger_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWe,
  input logic [2:0] cfgAddr,
  input logic       haltReq,
  input logic       irqReq,
  input logic [1:0] trigLevel,
  input logic       trigHit,
  input logic       twoLvl,
  input logic       trigOn
);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(haltReq && irqReq));

  a_r10_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (trigHit && !(cfgWe && cfgAddr == 3'd0)) |=> trigHit);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgAddr == 3'd0) |=> (!trigHit && !haltReq && !irqReq));

  a_r7_pulse_sets_hit: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq || irqReq) |-> trigHit);

  a_r8_needs_level2: assert property (@(posedge clk) disable iff (!rstN)
    ((haltReq || irqReq) && $past(twoLvl)) |-> ($past(trigLevel) == 2'd2));

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !trigOn |=> (!haltReq && !irqReq));

  a_r1_off_level: assert property (@(posedge clk) disable iff (!rstN)
    !trigOn |-> (trigLevel == 2'd0));
endmodule

bind dbg_trigger dbg_trigger_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
  .haltReq(haltReq), .irqReq(irqReq), .trigLevel(trigLevel),
  .trigHit(trigHit), .twoLvl(twoLvl), .trigOn(trigOn)
);

// File: tb/tb_dbg_trigger.sv
module tb_dbg_trigger;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [31:0] pcVal = '0, busAddr = '0, busData = '0;
  logic [7:0]  busAttr = '0;
  logic        busValid = 1'b0;
  logic        haltReq, irqReq, trigHit;
  logic [1:0]  trigLevel;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // bench's own register mirror and expected status
  logic [31:0] mReg [8];
  logic [1:0]  mLvl = 0;
  logic        mHit = 0, mHalt = 0, mIrq = 0;

  dbg_trigger dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .pcVal(pcVal), .busAddr(busAddr), .busData(busData), .busAttr(busAttr),
    .busValid(busValid), .haltReq(haltReq), .irqReq(irqReq),
    .trigLevel(trigLevel), .trigHit(trigHit)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (time %0t)", req, act, exp, $time);
    end
  endtask

  // condition vector {data, addr, pc} from the requirement text
  function automatic logic [2:0] condOf();
    logic attrOk, pcM, aM, dM;
    attrOk = ((busAttr ^ mReg[7][7:0]) & ~mReg[7][15:8]) == 8'h0;
    pcM = ((pcVal ^ mReg[1]) & ~mReg[2]) == 32'h0;
    aM  = busValid && attrOk && busAddr >= mReg[3] && busAddr <= mReg[4];
    dM  = busValid && attrOk && (((busData ^ mReg[5]) & ~mReg[6]) == 32'h0);
    return {dM, aM, pcM};
  endfunction

  function automatic logic levelTrue(input logic [2:0] en, input logic [2:0] c);
    return (en != 3'b0) && ((c & en) == en);
  endfunction

  // one clock: optional write, model update, compare all outputs
  task automatic cyc(input string req, input logic we, input logic [2:0] a, input logic [31:0] d);
    logic [2:0] c;
    logic l1, l2, fire, cw;
    logic [31:0] cfg;
    cfgWe = we; cfgAddr = a; cfgData = d;
    cfg = mReg[0];
    c  = condOf();
    l1 = levelTrue(cfg[2:0], c);
    l2 = levelTrue(cfg[5:3], c);
    cw = we && (a == 3'd0);
    fire = 1'b0;
    @(posedge clk);
    if (cfg[8] && !cw) begin
      if (!cfg[6]) fire = l1;
      else if (mLvl == 2'd2) begin
        if (l2) begin fire = 1'b1; mLvl = 2'd1; end
      end else if (l1) mLvl = 2'd2;
    end
    if (fire) mHit = 1'b1;
    mHalt = fire && !cfg[7];
    mIrq  = fire && cfg[7];
    if (we) mReg[a] = d;
    if (cw) begin mHit = 1'b0; mLvl = d[8] ? 2'd1 : 2'd0; end
    @(negedge clk);
    cfgWe = 1'b0;
    chk({req, " haltReq"}, {31'b0, haltReq}, {31'b0, mHalt});
    chk({req, " irqReq"}, {31'b0, irqReq}, {31'b0, mIrq});
    chk({req, " trigLevel"}, {30'b0, trigLevel}, {30'b0, mLvl});
    chk({req, " trigHit"}, {31'b0, trigHit}, {31'b0, mHit});
  endtask

  task automatic wr(input string req, input logic [2:0] a, input logic [31:0] d);
    cyc(req, 1'b1, a, d);
  endtask

  task automatic bus(input string req, input logic [31:0] p, input logic [31:0] ad,
                     input logic [31:0] dt, input logic [7:0] at, input logic v);
    pcVal = p; busAddr = ad; busData = dt; busAttr = at; busValid = v;
    cyc(req, 1'b0, 3'd0, 32'h0);
  endtask

  task automatic idle(input string req);
    bus(req, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'h0, 8'h0, 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !done) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mReg[i] = 32'h0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, matching PC with unit disabled does nothing
    chk("R1 haltReq", {31'b0, haltReq}, 32'h0);
    chk("R1 trigLevel", {30'b0, trigLevel}, 32'h0);
    chk("R1 trigHit", {31'b0, trigHit}, 32'h0);
    bus("R1 quiet", 32'h0, 32'h0, 32'h0, 8'h0, 1'b1);
    idle("R1");

    // R2: PC masked compare, single level, halt
    wr("R2", 3'd7, 32'h0000_FF00);
    wr("R2", 3'd1, 32'h0000_1000);
    wr("R2", 3'd2, 32'h0000_000F);
    wr("R2", 3'd0, 32'h0000_0101);
    bus("R2 masked hit", 32'h0000_100A, 0, 0, 0, 1'b0);
    bus("R2 outside mask", 32'h0000_1010, 0, 0, 0, 1'b0);
    bus("R7 repeat hit", 32'h0000_1000, 0, 0, 0, 1'b0);
    bus("R7 back to back", 32'h0000_1005, 0, 0, 0, 1'b0);
    idle("R2");

    // R3: inclusive address window, needs busValid
    wr("R3", 3'd3, 32'h0000_0200);
    wr("R3", 3'd4, 32'h0000_02FF);
    wr("R3", 3'd0, 32'h0000_0102);
    bus("R3 low bound", 0, 32'h200, 0, 8'h0, 1'b1);
    bus("R3 high bound", 0, 32'h2FF, 0, 8'h0, 1'b1);
    bus("R3 above", 0, 32'h300, 0, 8'h0, 1'b1);
    bus("R3 below", 0, 32'h1FF, 0, 8'h0, 1'b1);
    bus("R3 not valid", 0, 32'h250, 0, 8'h0, 1'b0);

    // R5: attribute qualification
    wr("R5", 3'd7, 32'h0000_F005);
    bus("R5 attr match", 0, 32'h250, 0, 8'h35, 1'b1);
    bus("R5 attr miss", 0, 32'h250, 0, 8'h04, 1'b1);

    // R4: masked data compare, irq action (R9)
    wr("R4", 3'd7, 32'h0000_FF00);
    wr("R4", 3'd5, 32'hCAFE_0000);
    wr("R4", 3'd6, 32'h0000_FFFF);
    wr("R9", 3'd0, 32'h0000_0184);
    bus("R4 hit R9 irq", 0, 0, 32'hCAFE_1234, 0, 1'b1);
    bus("R4 miss", 0, 0, 32'hCAFF_0000, 0, 1'b1);
    bus("R4 not valid", 0, 0, 32'hCAFE_0000, 0, 1'b0);

    // R6: AND of PC and address; empty enable set never fires
    wr("R6", 3'd0, 32'h0000_0103);
    bus("R6 pc only", 32'h0000_1000, 32'h0, 0, 0, 1'b1);
    bus("R6 both", 32'h0000_1000, 32'h280, 0, 0, 1'b1);
    wr("R6", 3'd0, 32'h0000_0100);
    bus("R6 no enables", 32'h0000_1000, 32'h280, 32'hCAFE_0000, 0, 1'b1);

    // R8: two level, level 1 = PC, level 2 = data, irq
    wr("R8", 3'd0, 32'h0000_01E1);
    bus("R8 l2 first ignored", 0, 0, 32'hCAFE_0000, 0, 1'b1);
    bus("R8 arm", 32'h0000_1000, 0, 0, 0, 1'b0);
    bus("R8 wait", 0, 0, 32'h0, 0, 1'b1);
    bus("R8 fire", 0, 0, 32'hCAFE_0001, 0, 1'b1);
    bus("R8 rearmed", 0, 0, 32'hCAFE_0001, 0, 1'b1);

    // R10: config write in same cycle as a PC hit
    wr("R10", 3'd0, 32'h0000_0101);
    bus("R10 hit", 32'h0000_1000, 0, 0, 0, 1'b0);
    cyc("R10 write beats hit", 1'b1, 3'd0, 32'h0000_0101);
    cyc("R10 write disables", 1'b1, 3'd0, 32'h0000_0001);
    bus("R1 disabled quiet", 32'h0000_1000, 0, 0, 0, 1'b0);

    // random phase
    for (int k = 0; k < 6; k++) begin
      logic [31:0] lo;
      lo = $urandom & 32'h00FF_FF00;
      wr("R2 rnd", 3'd1, $urandom);
      wr("R2 rnd", 3'd2, $urandom & 32'h0000_00FF);
      wr("R3 rnd", 3'd3, lo);
      wr("R3 rnd", 3'd4, lo + ($urandom & 32'h3FF));
      wr("R4 rnd", 3'd5, $urandom);
      wr("R4 rnd", 3'd6, $urandom & 32'h0000_0F0F);
      wr("R5 rnd", 3'd7, {16'h0, 4'hF, 4'($urandom), 8'($urandom)});
      wr("R6 rnd", 3'd0, 32'h100 | ($urandom & 32'hFF));
      for (int n = 0; n < 300; n++) begin
        logic [31:0] p, ad, dt;
        p  = ($urandom % 3 != 0) ? (mReg[1] ^ ($urandom & mReg[2])) : $urandom;
        ad = ($urandom % 3 != 0) ? (mReg[3] + ($urandom & 32'h3FF)) : $urandom;
        dt = ($urandom % 3 != 0) ? (mReg[5] ^ ($urandom & mReg[6])) : $urandom;
        if ($urandom % 40 == 0)
          cyc("R10 rnd write", 1'b1, 3'd0, ($urandom & 32'h1FF));
        else
          bus("R8 rnd", p, ad, dt, mReg[7][7:0] ^ 8'($urandom & 32'h30), $urandom % 5 != 0);
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule